// File: doc/BRIEF.md
# Port-I/O Address Decoder and Response Router

This block sits between a CPU port-I/O master and a set of byte-wide port peripherals. The master stalls until it sees an acknowledge. The block compares each 16-bit port address against a per-device match table and raises one one-hot device strobe. It then routes the selected device's combinational read byte back to the master and acknowledges in the same clock. Ports that match no entry complete at once and read as zero, so the master never hangs on a hole in the map.

Two paths can stretch the acknowledge. The first is a configured window of port numbers that is handed to a remote agent through a request/acknowledge pair. Any latency on that path is absorbed by holding the master. The second is a busy input from a designated device: while it is high, the acknowledge stays low, so the master stays parked for a whole burst. During a stretched access the device strobe is issued only in the first cycle. As a result, a write commits once and a read side effect fires once.

Top module: `pio_router`

## Requirements
- R1: The default device table decodes ports as follows. Device 0 takes 0x0020, 0x0021, 0x00A0 and 0x00A1. Device 1 takes 0x0040 to 0x0043. Device 2 takes 0x0060 and 0x0064. Device 3 takes 0x0C00 to 0x0C0F. Bit k of `dev_sel_o` is device k.
- R2: At most one of `dev_sel_o` and `fwd_req_o` is high in any cycle. When several table entries match, the lowest device index wins. The forwarded window is used only when no device entry matches.
- R3: A request to a local device with `burst_busy_i` low is acknowledged in the same cycle. `io_rdata_o` then carries the selected device's byte in bits 7:0 and zero in bits 31:8, for every size.
- R4: A request to a port that matches neither the table nor the forwarded window is acknowledged in the same cycle. It returns zero, raises no device strobe and raises no forwarding request.
- R5: The device strobe is high only in the first cycle of an access. A stalled access therefore commits a write, or triggers a read side effect, exactly once.
- R6: Ports 0x03F8 to 0x03FF raise `fwd_req_o`. The port, direction, size and write data are copied to the forwarding outputs and held until `fwd_ack_i`. The master's acknowledge and read data are `fwd_ack_i` and `fwd_rdata_i`, whatever the latency.
- R7: While `burst_busy_i` is high, `io_ack_o` is low for every request.
- R8: The size code (2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 = 4 bytes) passes unchanged to `fwd_size_o`. Local devices receive `io_wdata_i[7:0]`.
- R9: After reset, and with no request, all strobes, the forwarding request, the acknowledge and the read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_req_i | input | 1 | Master request valid |
| io_addr_i | input | 16 | Port number |
| io_we_i | input | 1 | 1 = write, 0 = read |
| io_size_i | input | 2 | Access size code |
| io_wdata_i | input | 32 | Write data |
| io_rdata_o | output | 32 | Read data to master |
| io_ack_o | output | 1 | Access complete |
| dev_sel_o | output | N_DEV | One-hot device strobes |
| dev_we_o | output | 1 | Direction to devices |
| dev_addr_o | output | 16 | Port number to devices |
| dev_wdata_o | output | 8 | Write byte to devices |
| dev_rdata_i | input | 8*N_DEV | Combinational read bytes, device k in bits 8k+7:8k |
| burst_busy_i | input | 1 | Designated device burst in progress |
| fwd_req_o | output | 1 | Forwarded access request |
| fwd_addr_o | output | 16 | Forwarded port |
| fwd_we_o | output | 1 | Forwarded direction |
| fwd_size_o | output | 2 | Forwarded size code |
| fwd_wdata_o | output | 32 | Forwarded write data |
| fwd_ack_i | input | 1 | Remote agent acknowledge |
| fwd_rdata_i | input | 32 | Remote agent read data |

## Verification
The hardest case to reach is a local read that is held stalled: its strobe must fire once while the master keeps the request up for several cycles. The bench forces that case by raising the busy input from a side process for a fixed number of cycles while a read of a side-effecting port is pending. It then compares the device model's read counter with one. A write that starts a burst in the device model reaches the same stall from the other side: the model's busy output rises combinationally on the start write. The forwarded window is driven through a remote model whose latency each scenario sets.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10
  } io_size_e;
endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode
  import pio_pkg::*;
#(
  parameter int unsigned N_DEV = 4,
  parameter logic [N_DEV-1:0][ADDR_W-1:0] DEV_BASE = '0,
  parameter logic [N_DEV-1:0][ADDR_W-1:0] DEV_MASK = '0,
  parameter logic [ADDR_W-1:0] FWD_LO = '0,
  parameter logic [ADDR_W-1:0] FWD_HI = '0
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_DEV-1:0]  sel_o,
  output logic              fwd_o
);
  logic [N_DEV-1:0] raw_hit;

  for (genvar g = 0; g < N_DEV; g++) begin : g_match
    assign raw_hit[g] = req_i && ((addr_i & DEV_MASK[g]) == DEV_BASE[g]);
  end

  // lowest index wins on overlap
  always_comb begin
    logic found;
    found = 1'b0;
    sel_o = '0;
    for (int i = 0; i < int'(N_DEV); i++) begin
      if (raw_hit[i] && !found) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
    fwd_o = req_i && !found && (addr_i >= FWD_LO) && (addr_i <= FWD_HI);
  end
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
  import pio_pkg::*;
#(
  parameter int unsigned N_DEV = 4
) (
  input  logic [N_DEV-1:0]        sel_i,
  input  logic                    fwd_i,
  input  logic [N_DEV*BYTE_W-1:0] dev_rdata_i,
  input  logic [DATA_W-1:0]       fwd_rdata_i,
  output logic [DATA_W-1:0]       rdata_o
);
  logic [BYTE_W-1:0] byte_q;

  always_comb begin
    byte_q = '0;
    for (int i = int'(N_DEV) - 1; i >= 0; i--) begin
      if (sel_i[i]) byte_q = dev_rdata_i[i*BYTE_W +: BYTE_W];
    end
    rdata_o = fwd_i ? fwd_rdata_i : {{(DATA_W-BYTE_W){1'b0}}, byte_q};
  end
endmodule

// File: rtl/pio_ack_ctrl.sv
module pio_ack_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic fwd_i,
  input  logic fwd_ack_i,
  input  logic burst_busy_i,
  output logic ack_o,
  output logic first_o
);
  logic issued_q;

  always_comb begin
    ack_o   = req_i && !burst_busy_i && (fwd_i ? fwd_ack_i : 1'b1);
    first_o = !issued_q;
  end

  // set while an access is stalled; cleared on completion or withdrawal
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) issued_q <= 1'b0;
    else         issued_q <= req_i && !ack_o;
  end
endmodule

// File: rtl/pio_router.sv
module pio_router
  import pio_pkg::*;
#(
  parameter int unsigned N_DEV = 4,
  parameter logic [N_DEV-1:0][ADDR_W-1:0] DEV_BASE =
    {16'h0C00, 16'h0060, 16'h0040, 16'h0020},
  parameter logic [N_DEV-1:0][ADDR_W-1:0] DEV_MASK =
    {16'hFFF0, 16'hFFFB, 16'hFFFC, 16'hFF7E},
  parameter logic [ADDR_W-1:0] FWD_LO = 16'h03F8,
  parameter logic [ADDR_W-1:0] FWD_HI = 16'h03FF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    io_req_i,
  input  logic [15:0]             io_addr_i,
  input  logic                    io_we_i,
  input  logic [1:0]              io_size_i,
  input  logic [31:0]             io_wdata_i,
  output logic [31:0]             io_rdata_o,
  output logic                    io_ack_o,
  output logic [N_DEV-1:0]        dev_sel_o,
  output logic                    dev_we_o,
  output logic [15:0]             dev_addr_o,
  output logic [7:0]              dev_wdata_o,
  input  logic [N_DEV*8-1:0]      dev_rdata_i,
  input  logic                    burst_busy_i,
  output logic                    fwd_req_o,
  output logic [15:0]             fwd_addr_o,
  output logic                    fwd_we_o,
  output logic [1:0]              fwd_size_o,
  output logic [31:0]             fwd_wdata_o,
  input  logic                    fwd_ack_i,
  input  logic [31:0]             fwd_rdata_i
);
  logic [N_DEV-1:0] dec_sel;
  logic             fwd_hit;
  logic             first_cyc;

  pio_addr_decode #(
    .N_DEV(N_DEV), .DEV_BASE(DEV_BASE), .DEV_MASK(DEV_MASK),
    .FWD_LO(FWD_LO), .FWD_HI(FWD_HI)
  ) u_dec (
    .req_i (io_req_i),
    .addr_i(io_addr_i),
    .sel_o (dec_sel),
    .fwd_o (fwd_hit)
  );

  pio_rd_mux #(.N_DEV(N_DEV)) u_mux (
    .sel_i      (dec_sel),
    .fwd_i      (fwd_hit),
    .dev_rdata_i(dev_rdata_i),
    .fwd_rdata_i(fwd_rdata_i),
    .rdata_o    (io_rdata_o)
  );

  pio_ack_ctrl u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (io_req_i),
    .fwd_i       (fwd_hit),
    .fwd_ack_i   (fwd_ack_i),
    .burst_busy_i(burst_busy_i),
    .ack_o       (io_ack_o),
    .first_o     (first_cyc)
  );

  // strobe only in the first cycle so stalled accesses act once
  assign dev_sel_o   = dec_sel & {N_DEV{first_cyc}};
  assign dev_we_o    = io_we_i;
  assign dev_addr_o  = io_addr_i;
  assign dev_wdata_o = io_wdata_i[7:0];

  assign fwd_req_o   = fwd_hit;
  assign fwd_addr_o  = io_addr_i;
  assign fwd_we_o    = io_we_i;
  assign fwd_size_o  = io_size_i;
  assign fwd_wdata_o = io_wdata_i;
endmodule

// File: rtl/pio_router_chk.sv
module pio_router_chk #(
  parameter int unsigned N_DEV = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             io_req_i,
  input logic             io_ack_o,
  input logic [31:0]      io_rdata_o,
  input logic [N_DEV-1:0] dev_sel_o,
  input logic [N_DEV-1:0] dec_sel,
  input logic             fwd_req_o,
  input logic [15:0]      fwd_addr_o,
  input logic             fwd_ack_i,
  input logic [31:0]      fwd_rdata_i,
  input logic             burst_busy_i
);
  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fwd_req_o, dec_sel}));

  p_local_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_i && !burst_busy_i && !fwd_req_o) |-> io_ack_o);

  p_undec_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_i && dec_sel == '0 && !fwd_req_o) |-> (io_rdata_o == '0 && dev_sel_o == '0));

  p_strobe_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_sel_o != '0 && !io_ack_o) |=> (dev_sel_o == '0));

  p_fwd_resp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_req_o && !burst_busy_i) |-> (io_ack_o == fwd_ack_i && io_rdata_o == fwd_rdata_i));

  p_fwd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_req_o && !fwd_ack_i) |=> (fwd_req_o && $stable(fwd_addr_o)));

  p_burst_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_busy_i |-> !io_ack_o);

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_req_i |-> (!io_ack_o && dev_sel_o == '0 && !fwd_req_o));
endmodule

bind pio_router pio_router_chk #(.N_DEV(N_DEV)) u_chk (.*);

// File: tb/sim_pio_router.sv
`timescale 1ns/1ps
module sim_pio_router;
  localparam int N = 4;
  localparam int BURST_LEN = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_we = 1'b0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        io_ack;
  logic [N-1:0] dev_sel;
  logic        dev_we;
  logic [15:0] dev_addr;
  logic [7:0]  dev_wdata;
  logic [N*8-1:0] dev_rdata;
  logic        burst_busy;
  logic        fwd_req, fwd_we, fwd_ack;
  logic [15:0] fwd_addr;
  logic [1:0]  fwd_size;
  logic [31:0] fwd_wdata, fwd_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pio_router u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .io_req_i(io_req), .io_addr_i(io_addr), .io_we_i(io_we),
    .io_size_i(io_size), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .io_ack_o(io_ack),
    .dev_sel_o(dev_sel), .dev_we_o(dev_we), .dev_addr_o(dev_addr),
    .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata),
    .burst_busy_i(burst_busy),
    .fwd_req_o(fwd_req), .fwd_addr_o(fwd_addr), .fwd_we_o(fwd_we),
    .fwd_size_o(fwd_size), .fwd_wdata_o(fwd_wdata),
    .fwd_ack_i(fwd_ack), .fwd_rdata_i(fwd_rdata)
  );

  // device models
  logic [7:0] dev_reg [N];
  int wr_cnt [N];
  int rd_cnt [N];
  int burst_cnt = 0;
  logic force_busy = 1'b0;
  int sel_viol = 0;

  always_comb
    for (int k = 0; k < N; k++) dev_rdata[k*8 +: 8] = dev_reg[k];

  assign burst_busy = force_busy || (burst_cnt != 0) ||
                      (dev_sel[3] && dev_we && dev_wdata[0]);

  always @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (dev_sel[k] && dev_we) begin dev_reg[k] <= dev_wdata; wr_cnt[k] <= wr_cnt[k] + 1; end
      if (dev_sel[k] && !dev_we) rd_cnt[k] <= rd_cnt[k] + 1;
    end
    if (dev_sel[3] && dev_we && dev_wdata[0]) burst_cnt <= BURST_LEN;
    else if (burst_cnt != 0) burst_cnt <= burst_cnt - 1;
    if ($countones({fwd_req, dev_sel}) > 1) sel_viol <= sel_viol + 1;
  end

  // remote agent
  int fwd_lat = 1;
  int fwd_cnt = 0;
  int fwd_seen = 0;
  logic [15:0] last_faddr;
  logic [1:0]  last_fsize;
  logic [31:0] last_fwdata;
  logic        last_fwe;
  assign fwd_rdata = {16'hBEEF, fwd_addr};

  initial fwd_ack = 1'b0;
  always @(posedge clk) begin
    if (fwd_ack) begin
      fwd_ack <= 1'b0; fwd_cnt <= 0; fwd_seen <= fwd_seen + 1;
      last_faddr <= fwd_addr; last_fsize <= fwd_size;
      last_fwdata <= fwd_wdata; last_fwe <= fwd_we;
    end else if (fwd_req) begin
      if (fwd_cnt >= fwd_lat - 1) fwd_ack <= 1'b1;
      else fwd_cnt <= fwd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_xfer(input logic [15:0] a, input logic we, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    io_req = 1'b1; io_addr = a; io_we = we; io_size = sz; io_wdata = wd;
    cyc = 0;
    #1;
    while (!io_ack && cyc < 1000) begin
      @(negedge clk); #1; cyc++;
    end
    rd = io_rdata;
    @(posedge clk); #1;
    io_req = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(io_ack == 0 && dev_sel == 0 && fwd_req == 0 && io_rdata == 0, "R9 idle outputs",
        {io_ack, dev_sel, fwd_req}, 0);
  endtask

  task automatic t_decode();
    logic [31:0] rd; int c;
    io_xfer(16'h00A1, 1, 2'b00, 32'h5A, rd, c);
    io_xfer(16'h0021, 0, 2'b00, 0, rd, c);
    chk(rd == 32'h5A, "R1 0xA1/0x21 same device", rd, 32'h5A);
    io_xfer(16'h0043, 1, 2'b00, 32'h33, rd, c);
    io_xfer(16'h0064, 1, 2'b00, 32'h64, rd, c);
    io_xfer(16'h0C0F, 1, 2'b00, 32'h0E, rd, c);
    chk(wr_cnt[0] == 1 && wr_cnt[1] == 1 && wr_cnt[2] == 1 && wr_cnt[3] == 1,
        "R1 one write per device", {wr_cnt[0][7:0], wr_cnt[1][7:0], wr_cnt[2][7:0], wr_cnt[3][7:0]},
        32'h01010101);
    io_xfer(16'h0060, 0, 2'b00, 0, rd, c);
    chk(rd == 32'h64, "R1 0x60 reads device 2", rd, 32'h64);
    chk(sel_viol == 0, "R2 at most one select", sel_viol, 0);
  endtask

  task automatic t_local_ack();
    logic [31:0] rd; int c;
    io_xfer(16'h0040, 0, 2'b10, 0, rd, c);
    chk(c == 0, "R3 same-cycle ack", c, 0);
    chk(rd == 32'h0000_0033, "R3 zero-extended byte on dword read", rd, 32'h33);
  endtask

  task automatic t_undecoded();
    logic [31:0] rd; int c; int w0;
    w0 = wr_cnt[0] + wr_cnt[1] + wr_cnt[2] + wr_cnt[3];
    io_xfer(16'h0300, 0, 2'b00, 0, rd, c);
    chk(rd == 0 && c == 0, "R4 undecoded read zero, no stall", {rd[15:0], c[15:0]}, 0);
    io_xfer(16'h0022, 1, 2'b00, 32'hFF, rd, c);
    io_xfer(16'h0061, 1, 2'b00, 32'hFF, rd, c);
    chk(c == 0, "R4 undecoded write no stall", c, 0);
    chk(wr_cnt[0] + wr_cnt[1] + wr_cnt[2] + wr_cnt[3] == w0 && fwd_seen == 0,
        "R4 no device or remote touched", wr_cnt[0] + wr_cnt[1] + wr_cnt[2] + wr_cnt[3], w0);
    io_xfer(16'h0020, 0, 2'b00, 0, rd, c);
    chk(rd == 32'h5A, "R4 device 0 unchanged", rd, 32'h5A);
  endtask

  task automatic t_stall_once();
    logic [31:0] rd; int c; int r0;
    r0 = rd_cnt[1];
    force_busy = 1'b1;
    fork
      begin repeat (3) @(posedge clk); #1 force_busy = 1'b0; end
    join_none
    io_xfer(16'h0041, 0, 2'b00, 0, rd, c);
    chk(c >= 2, "R7 ack held while busy", c, 2);
    chk(rd_cnt[1] == r0 + 1, "R5 read side effect once", rd_cnt[1], r0 + 1);
    chk(rd == 32'h33, "R5 stalled read data", rd, 32'h33);
  endtask

  task automatic t_forward(input int lat);
    logic [31:0] rd; int c; int s0;
    s0 = fwd_seen;
    fwd_lat = lat;
    io_xfer(16'h03FA, 0, 2'b01, 0, rd, c);
    chk(c == lat, "R6 forwarded latency", c, lat);
    chk(rd == 32'hBEEF_03FA, "R6 remote read data", rd, 32'hBEEF03FA);
    io_xfer(16'h03FF, 1, 2'b10, 32'hCAFE_0001, rd, c);
    @(negedge clk);
    chk(fwd_seen == s0 + 2, "R6 one remote ack per access", fwd_seen, s0 + 2);
    chk(last_faddr == 16'h03FF && last_fwe == 1 && last_fwdata == 32'hCAFE_0001,
        "R6 forwarded fields", last_fwdata, 32'hCAFE0001);
    chk(last_fsize == 2'b10, "R8 size passed through", last_fsize, 2'b10);
  endtask

  task automatic t_burst();
    logic [31:0] rd; int c;
    io_xfer(16'h0C00, 1, 2'b00, 32'h81, rd, c);
    chk(c == BURST_LEN + 1, "R7 master held for burst", c, BURST_LEN + 1);
    chk(wr_cnt[3] == 2, "R5 burst start write once", wr_cnt[3], 2);
    io_xfer(16'h0C05, 0, 2'b00, 0, rd, c);
    chk(rd == 32'h81 && c == 0, "R8 low byte to device", rd, 32'h81);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin dev_reg[k] = '0; wr_cnt[k] = 0; rd_cnt[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_local_ack();
    t_undecoded();
    t_stall_once();
    t_forward(1);
    t_forward(4);
    t_burst();
    chk(sel_viol == 0, "R2 exclusive selects overall", sel_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule